// File: doc/BRIEF.md
# Wide-Block Streaming Transfer Engine

This engine moves a run of data between a wide shared memory and a local agent at one 32-bit word per clock. The shared memory is organised in blocks of eight words ("wides"). It serves a requester only on the cycle its arbiter raises a window strobe, which happens once in every eight clocks. On the local side the agent sees one conduit. In fetch mode each accepted read of the conduit takes the next word. In store mode each accepted write hands over the next word.

Two eight-word slots alternate as fill and drain buffers. Because of this the next wide is fetched, or the previous one committed, while the current one streams through the conduit. The stream therefore continues across window gaps. A start pulse carries the direction, the wide count, the first wide address and the number of valid words in the final wide. When the conduit cannot serve an access, the engine raises a stall flag. It never invents or loses data.

Top module: `wide_stream_engine`

## Requirements
- R1: A wide is 8 words. `mem_addr` is a wide index. Word i of a wide occupies bits [32*i+31:32*i] of `mem_rdata`, `mem_wdata`, and bit i of `mem_wbe`.
- R2: `start` loads a transfer only while `busy` is low and is ignored while `busy` is high. A wide count of zero leaves the engine idle.
- R3: The first shared access of a transfer uses the start address, and the address advances by one after every wide access.
- R4: `mem_rd` and `mem_wr` are only raised in a cycle where `mem_window` is high, and never both together.
- R5: In fetch mode (`start_dir` = 0) the conduit presents the words in address order, word 0 of each wide first, and an accepted `cdt_rd` moves to the next word.
- R6: In fetch mode the first word is readable between 2 and 9 clocks after the start edge, depending on the window phase.
- R7: In store mode (`start_dir` = 1) the first word is accepted in the first clock after the start edge.
- R8: Once the first word has moved, an agent that accesses the conduit every clock sees no stall until the transfer ends, in either direction and for any window phase.
- R9: `stall` is high exactly when a conduit access cannot be served: no word is ready (fetch), no slot space is free (store), the engine is idle, or the mode is wrong. A stalled access has no effect.
- R10: `busy` stays high until the last word is taken in fetch mode, or until the last wide is written to memory in store mode. It falls on the next clock after that.
- R11: `start_tail` gives the valid words in the final wide (0 or 8 mean a full wide). In fetch mode only that many words are delivered. In store mode the final write enables only words 0 to tail-1 in `mem_wbe`. Every other store write enables all eight words.
- R12: During and right after reset, `busy`, `stall`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| start_dir | input | 1 | 0 fetch from memory, 1 store to memory |
| start_wides | input | CNT_W | Number of wides to move |
| start_tail | input | 4 | Valid words in final wide (0 = 8) |
| start_ptr | input | PTR_W | First wide address |
| busy | output | 1 | Transfer in progress |
| mem_window | input | 1 | Access window strobe from the arbiter |
| mem_rd | output | 1 | Wide read this cycle |
| mem_wr | output | 1 | Wide write this cycle |
| mem_addr | output | PTR_W | Wide address |
| mem_rdata | input | 256 | Wide read data, valid in the access cycle |
| mem_wdata | output | 256 | Wide write data |
| mem_wbe | output | 8 | Per-word write enables |
| cdt_rd | input | 1 | Conduit read request |
| cdt_rdata | output | 32 | Conduit word, valid when `cdt_rd` is not stalled |
| cdt_wr | input | 1 | Conduit write request |
| cdt_wdata | input | 32 | Conduit write word |
| stall | output | 1 | Conduit access not served this cycle |

## Verification
A fetched wide is captured on the clock edge that ends its window cycle, so the word is visible from the next sample. The first word can therefore appear no earlier than the second sample after start and no later than the ninth. A store is accepted on the very first sample. `busy` falls on the sample after the final pop or final commit. Every conduit and `busy` value is read at the falling edge plus one step, after the preceding rising edge has settled. Each accepted word is compared against the address-derived pattern expected at that count, so a word that is early, late, repeated or skipped shows up as a data mismatch or as a stall after streaming has begun.

// File: rtl/wse_pkg.sv
// Shared constants and types for the wide-block streaming engine.
// Assumes fixed 32-bit words packed eight to a wide.
package wse_pkg;
    localparam int WORD_W     = 32;
    localparam int WIDE_WORDS = 8;
    localparam int WIDE_W     = WORD_W * WIDE_WORDS;
    localparam int IDX_W      = $clog2(WIDE_WORDS);
    localparam int TAIL_W     = IDX_W + 1;

    typedef enum logic {
        DIR_FETCH = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/wse_slots.sv
// Two wide-sized slots. A whole-wide write port (memory side) and a
// single-word write port (conduit side); a whole-wide read and a word read.
// Assumes the control never writes the same slot from both ports at once.
module wse_slots
    import wse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_we,
    input  logic              wide_sel,
    input  logic [WIDE_W-1:0] wide_in,
    input  logic              word_we,
    input  logic              word_sel,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_wide_sel,
    output logic [WIDE_W-1:0] wide_out,
    input  logic              rd_word_sel,
    input  logic [IDX_W-1:0]  rd_word_idx,
    output logic [WORD_W-1:0] word_out
);
    logic [WIDE_W-1:0] slot_q [2];

    for (genvar s = 0; s < 2; s++) begin : g_slot
        // Load a whole wide or patch one word of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wide_we && (wide_sel == 1'(s)))
                slot_q[s] <= wide_in;
            else if (word_we && (word_sel == 1'(s)))
                slot_q[s][int'(word_idx)*WORD_W +: WORD_W] <= word_in;
        end
    end

    // Read ports are combinational views of the selected slot.
    assign wide_out = slot_q[rd_wide_sel];
    assign word_out = slot_q[rd_word_sel][int'(rd_word_idx)*WORD_W +: WORD_W];
endmodule

// File: rtl/wse_wide_ptr.sv
// Memory-side wide pointer and remaining-wide counter.
// Loads on start, advances pointer and counts down on each wide access.
module wse_wide_ptr #(
    parameter int CNT_W = 8,
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] left
);
    // Pointer post-increments and count decrements per transferred wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            left <= '0;
        end else if (load) begin
            ptr  <= load_ptr;
            left <= load_cnt;
        end else if (step) begin
            ptr  <= ptr + 1'b1;
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/wide_stream_engine.sv
// Streams wides between a windowed shared memory and a one-word conduit.
// Two slots ping-pong: one side produces whole slots, the other consumes.
// Assumes the shared memory returns read data in the window cycle itself.
module wide_stream_engine
    import wse_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PTR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_dir,
    input  logic [CNT_W-1:0]      start_wides,
    input  logic [TAIL_W-1:0]     start_tail,
    input  logic [PTR_W-1:0]      start_ptr,
    output logic                  busy,
    input  logic                  mem_window,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [PTR_W-1:0]      mem_addr,
    input  logic [WIDE_W-1:0]     mem_rdata,
    output logic [WIDE_W-1:0]     mem_wdata,
    output logic [WIDE_WORDS-1:0] mem_wbe,
    input  logic                  cdt_rd,
    output logic [WORD_W-1:0]     cdt_rdata,
    input  logic                  cdt_wr,
    input  logic [WORD_W-1:0]     cdt_wdata,
    output logic                  stall
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDE_WORDS - 1);

    xfer_dir_e        dir_q;
    logic [IDX_W-1:0] tail_idx_q;
    logic [CNT_W-1:0] loc_left_q;
    logic [CNT_W-1:0] mem_left;
    logic [IDX_W-1:0] word_q;
    logic             loc_sel_q;
    logic             mem_sel_q;
    logic [1:0]       held_q;

    logic load, store, rd_ok, wr_ok, loc_go, loc_last, loc_step;
    logic mem_go, mem_last, produce, consume;

    assign load     = start && !busy;
    assign busy     = (loc_left_q != '0) || (mem_left != '0);
    assign store    = (dir_q == DIR_STORE);
    assign loc_last = (loc_left_q == CNT_W'(1)) ? (word_q == tail_idx_q) : (word_q == LAST_IDX);
    assign mem_last = (mem_left == CNT_W'(1));

    // Conduit side: serviceable when data (fetch) or space (store) exists.
    assign rd_ok    = !store && (held_q != 2'd0);
    assign wr_ok    = store && (loc_left_q != '0) && (held_q != 2'd2);
    assign loc_go   = (cdt_rd && rd_ok) || (cdt_wr && wr_ok);
    assign loc_step = loc_go && loc_last;
    assign stall    = (cdt_rd && !rd_ok) || (cdt_wr && !wr_ok);

    // Memory side: fetch into a free slot, or commit a completed slot.
    assign mem_go = mem_window && (store ? (held_q != 2'd0)
                                         : ((mem_left != '0) && (held_q != 2'd2)));
    assign mem_rd = mem_go && !store;
    assign mem_wr = mem_go && store;

    assign produce = store ? loc_step : mem_go;
    assign consume = store ? mem_go : loc_step;

    // Per-word enables: full on every commit except a short final wide.
    always_comb begin
        for (int i = 0; i < WIDE_WORDS; i++)
            mem_wbe[i] = mem_wr && (!mem_last || (IDX_W'(i) <= tail_idx_q));
    end

    // Transfer setup and slot bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q      <= DIR_FETCH;
            tail_idx_q <= LAST_IDX;
            held_q     <= 2'd0;
            mem_sel_q  <= 1'b0;
        end else if (load) begin
            dir_q      <= xfer_dir_e'(start_dir);
            tail_idx_q <= ((start_tail == '0) || (start_tail >= TAIL_W'(WIDE_WORDS)))
                          ? LAST_IDX : IDX_W'(start_tail - 1'b1);
            held_q     <= 2'd0;
            mem_sel_q  <= 1'b0;
        end else begin
            held_q <= held_q + {1'b0, produce} - {1'b0, consume};
            if (mem_go)
                mem_sel_q <= !mem_sel_q;
        end
    end

    // Conduit cursor: word index, slot select and wides left locally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_left_q <= '0;
            word_q     <= '0;
            loc_sel_q  <= 1'b0;
        end else if (load) begin
            loc_left_q <= start_wides;
            word_q     <= '0;
            loc_sel_q  <= 1'b0;
        end else if (loc_go) begin
            if (loc_last) begin
                word_q     <= '0;
                loc_sel_q  <= !loc_sel_q;
                loc_left_q <= loc_left_q - 1'b1;
            end else begin
                word_q <= word_q + 1'b1;
            end
        end
    end

    wse_wide_ptr #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_ptr (start_ptr),
        .load_cnt (start_wides),
        .step     (mem_go),
        .ptr      (mem_addr),
        .left     (mem_left)
    );

    wse_slots u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_we     (mem_rd),
        .wide_sel    (mem_sel_q),
        .wide_in     (mem_rdata),
        .word_we     (loc_go && store),
        .word_sel    (loc_sel_q),
        .word_idx    (word_q),
        .word_in     (cdt_wdata),
        .rd_wide_sel (mem_sel_q),
        .wide_out    (mem_wdata),
        .rd_word_sel (loc_sel_q),
        .rd_word_idx (word_q),
        .word_out    (cdt_rdata)
    );
endmodule

// File: rtl/wse_checker.sv
// Port-level properties of the streaming engine, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module wse_checker #(
    parameter int PTR_W = 16,
    parameter int WBE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mem_window,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [PTR_W-1:0] mem_addr,
    input logic [WBE_W-1:0] mem_wbe,
    input logic             cdt_rd,
    input logic             cdt_wr,
    input logic             stall
);
    // R4
    win_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> mem_window);
    // R4
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> (mem_addr == PTR_W'($past(mem_addr) + 1'b1)));
    // R9
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (cdt_rd || cdt_wr));
    // R9
    idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cdt_rd || cdt_wr)) |-> stall);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr));
    // R11
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wbe[0] && ((mem_wbe & WBE_W'(mem_wbe + 1'b1)) == '0)));
    // R11
    be_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> (mem_wbe == '0));
endmodule

bind wide_stream_engine wse_checker #(.PTR_W(PTR_W), .WBE_W(8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_window (mem_window),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wbe    (mem_wbe),
    .cdt_rd     (cdt_rd),
    .cdt_wr     (cdt_wr),
    .stall      (stall)
);

// File: tb/wide_stream_engine_test.sv
`timescale 1ns/1ps
module wide_stream_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         start_dir = 1'b0;
    logic [7:0]   start_wides = '0;
    logic [3:0]   start_tail = '0;
    logic [15:0]  start_ptr = '0;
    logic         busy;
    logic         mem_window;
    logic         mem_rd, mem_wr;
    logic [15:0]  mem_addr;
    logic [255:0] mem_rdata, mem_wdata;
    logic [7:0]   mem_wbe;
    logic         cdt_rd = 1'b0;
    logic [31:0]  cdt_rdata;
    logic         cdt_wr = 1'b0;
    logic [31:0]  cdt_wdata = '0;
    logic         stall;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [255:0] mem [64];
    logic         prefill_req = 1'b0;
    int           seed = 0;
    logic [2:0]   win_cnt = '0;
    logic [2:0]   phase = '0;
    int           off_window = 0;

    // {dir, wides[3:0], tail[3:0], base[5:0], phase[2:0]}
    localparam int NV = 7;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 4'd3, 4'd0, 6'd2,  3'd0},
        {1'b0, 4'd2, 4'd3, 6'd10, 3'd5},
        {1'b1, 4'd3, 4'd0, 6'd20, 3'd3},
        {1'b1, 4'd2, 4'd5, 6'd30, 3'd7},
        {1'b0, 4'd1, 4'd1, 6'd40, 3'd2},
        {1'b1, 4'd1, 4'd8, 6'd50, 3'd1},
        {1'b1, 4'd4, 4'd1, 6'd56, 3'd6}
    };

    wide_stream_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
        .start_wides(start_wides), .start_tail(start_tail), .start_ptr(start_ptr),
        .busy(busy), .mem_window(mem_window), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_wbe(mem_wbe), .cdt_rd(cdt_rd), .cdt_rdata(cdt_rdata),
        .cdt_wr(cdt_wr), .cdt_wdata(cdt_wdata), .stall(stall)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input int a, input int w, input int s);
        return (32'(s) * 32'h0100_0193) ^ (32'(a) << 8) ^ 32'(w) ^ 32'h5500_0000;
    endfunction

    function automatic logic [31:0] wpat(input int b, input int k);
        return 32'hC0DE_0000 ^ (32'(b) << 8) ^ 32'(k);
    endfunction

    // Arbiter model: window strobe once every 8 clocks at a chosen phase.
    always @(negedge clk) win_cnt <= win_cnt + 3'd1;
    assign mem_window = (win_cnt == phase);

    // Shared memory model: combinational read, per-word enabled write.
    assign mem_rdata = mem[mem_addr[5:0]];
    always @(posedge clk) begin
        if (prefill_req) begin
            for (int a = 0; a < 64; a++)
                for (int w = 0; w < 8; w++)
                    mem[a][w*32 +: 32] <= pat(a, w, seed);
        end else if (mem_wr) begin
            for (int w = 0; w < 8; w++)
                if (mem_wbe[w]) mem[mem_addr[5:0]][w*32 +: 32] <= mem_wdata[w*32 +: 32];
        end
        if ((mem_rd || mem_wr) && !mem_window) off_window <= off_window + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic prefill(input int s);
        seed = s;
        @(negedge clk) prefill_req = 1'b1;
        @(negedge clk) prefill_req = 1'b0;
    endtask

    // One transfer: optional start poke while busy (fetch only).
    task automatic run_xfer(input logic d, input int nw, input int tl, input int b,
                            input logic [2:0] ph, input bit poke);
        int te, tot, k, cyc, first, stalls;
        te = (tl == 0 || tl >= 8) ? 8 : tl;
        tot = (nw - 1) * 8 + te;
        phase = ph;
        prefill(b + 1);
        @(negedge clk);
        start = 1'b1; start_dir = d; start_wides = 8'(nw);
        start_tail = 4'(tl); start_ptr = 16'(b);
        @(negedge clk);
        start = 1'b0;
        k = 0; cyc = 0; first = -1; stalls = 0;
        while (k < tot && cyc < 200) begin
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b1; start_dir = 1'b1; start_wides = 8'd9; start_ptr = 16'd0;
            end else begin
                start = 1'b0;
            end
            if (!d) cdt_rd = 1'b1;
            else begin cdt_wr = 1'b1; cdt_wdata = wpat(b, k); end
            #1;
            if (!stall) begin
                if (first < 0) first = cyc;
                // R5 fetched word order and content
                if (!d) chk("R5 fetch word", cdt_rdata, pat(b + k/8, k%8, b + 1));
                if (k == tot - 1) chk("R10 busy at last word", 32'(busy), 32'd1);
                k++;
            end else if (first >= 0) stalls++;
            @(negedge clk);
        end
        cdt_rd = 1'b0; cdt_wr = 1'b0; start = 1'b0;
        chk("R8 sustained, no stall mid-stream", 32'(stalls), 32'd0);
        if (!d) begin
            chk("R6 first word at or after 2", 32'(first >= 2), 32'd1);
            chk("R6 first word by 9", 32'(first <= 9 && first > 0), 32'd1);
            #1;
            chk("R10 busy falls after last pop", 32'(busy), 32'd0);
            cdt_rd = 1'b1; #1;
            chk("R11 no word past tail", 32'(stall), 32'd1);
            @(negedge clk) cdt_rd = 1'b0;
        end else begin
            chk("R7 first push accepted", 32'(first), 32'd1);
            #1;
            chk("R10 busy until commit", 32'(busy), 32'd1);
            cyc = 0;
            while (busy && cyc < 40) begin @(negedge clk); #1; cyc++; end
            chk("R10 store finishes", 32'(busy), 32'd0);
            for (int a = 0; a < nw; a++)
                for (int w = 0; w < 8; w++)
                    // R11 written words vs untouched tail words
                    chk("R11 stored word", mem[b + a][w*32 +: 32],
                        (a*8 + w < tot) ? wpat(b, a*8 + w) : pat(b + a, w, b + 1));
            if (b + nw < 64) chk("R3 wide past range untouched", mem[b + nw][31:0], pat(b + nw, 0, b + 1));
            if (b > 0) chk("R3 wide before base untouched", mem[b - 1][31:0], pat(b - 1, 0, b + 1));
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R12 reset busy", 32'(busy), 32'd0);
        chk("R12 reset mem access", 32'(mem_rd || mem_wr), 32'd0);
        chk("R12 reset stall", 32'(stall), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R12 after reset busy", 32'(busy), 32'd0);
        chk("R12 after reset stall", 32'(stall), 32'd0);

        // R9 idle conduit access stalls
        cdt_rd = 1'b1; #1;
        chk("R9 idle read stalls", 32'(stall), 32'd1);
        cdt_rd = 1'b0; cdt_wr = 1'b1; #1;
        chk("R9 idle write stalls", 32'(stall), 32'd1);
        @(negedge clk) cdt_wr = 1'b0;

        // R2 zero wide count stays idle
        start = 1'b1; start_wides = 8'd0; start_dir = 1'b0;
        @(negedge clk) start = 1'b0; #1;
        chk("R2 zero count idle", 32'(busy), 32'd0);

        for (int i = 0; i < NV; i++)
            run_xfer(VEC[i][17], int'(VEC[i][16:13]), int'(VEC[i][12:9]),
                     int'(VEC[i][8:3]), VEC[i][2:0], 1'b0);

        // R2 start while busy ignored: fetch data still from the first base
        run_xfer(1'b0, 2, 0, 4, 3'd4, 1'b1);

        // R1 word lanes: first fetched word matches lane 0 of the wide
        chk("R1 lane 0 of wide 4", mem[4][31:0], pat(4, 0, 5));
        chk("R4 accesses only in window", 32'(off_window), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule